// File: doc/BRIEF.md
# Model-Specific Register Access Unit

This block holds the 64-bit model-specific registers of a CPU core and serves the core's read and write requests to them. A request names a register by a 32-bit index. Write data arrives as two 32-bit halves, and read data leaves the same way. Before a write commits, the block checks it against rules kept per register:
- the privilege of the requester,
- read-only status,
- memory-type encodings,
- reserved feature bits,
- canonical address form,
- the rule that long mode may not be toggled while paging is on.

A failed check raises a general-protection fault flag and changes nothing.

The registers held here are:
- the variable and fixed memory-range registers and the default-type register,
- the page attribute register,
- the capability register,
- the extended feature register,
- the four system-call registers,
- the three segment base registers,
- the interrupt-controller base register.

When the interrupt-controller base changes, the block pulses a strobe to the interrupt controller. The controller itself is outside this block.

A request is a one-cycle `req_valid` pulse. The response arrives on the next cycle, registered and flagged by `rsp_done`.

Top module: `msr_unit`

## Requirements
- R1: When `real_mode` is 0 and `cpl` is not 0, every read and every write faults, read data is zero and no register changes. With `real_mode` at 1, any `cpl` is allowed.
- R2: A request accepted at a clock edge produces `rsp_done` = 1 for exactly one cycle after that edge, together with `rsp_fault`. Writes and faulted accesses return zero on `rsp_lo` and `rsp_hi`. An idle cycle leaves `rsp_done` at 0.
- R3: The following writes fault unless their low byte is one of 0x00, 0x01, 0x04, 0x05 or 0x06:
  - variable-range base writes (even indices 0x200..0x20F),
  - fixed-range writes (0x250, 0x258, 0x259, 0x268..0x26F),
  - default-type writes (0x2FF).
  Variable-range mask writes (odd indices 0x201..0x20F) are stored unchecked.
- R4: A write to the page attribute register (0x277) faults unless all eight bytes are in {0x00, 0x01, 0x04, 0x05, 0x06, 0x07}.
- R5: The capability register (0xFE) reads 0x508 low and 0 high. A write to it faults.
- R6: A write to the extended feature register (0xC0000080) faults if it sets any bit outside the supported mask 0xD01.
- R7: A write to the extended feature register faults if it changes bit 8 (long-mode enable) while `paging_en` is 1. Bit 10 (long-mode active) keeps its previous value whatever is written.
- R8: Writes to the following registers fault unless bits 63..47 of the value are all equal:
  - 0xC0000082 and 0xC0000083 (system-call targets),
  - 0xC0000100 and 0xC0000101 (segment bases),
  - 0xC0000102 (swap base).
  The selector register 0xC0000081 is stored unchecked.
- R9: A write to the interrupt-controller base register (0x1B) never faults. It commits only if bit 11 of the current value is 1, and then stores only the low 32 bits and pulses `apic_upd` together with `rsp_done`. Otherwise it is dropped. Reads return high half 0.
- R10: With the default parameters, a read or write to any other index faults.
- R11: After reset:
  - memory-range registers and the default-type register read 0,
  - the page attribute register reads 0x0007040600070406,
  - the interrupt-controller base reads 0xFEE00800.
- R12: The default-type register (0x2FF) and the flag-mask register (0xC0000084) keep only the low 32 bits of a write and read back 0 in the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Register index |
| req_lo | input | 32 | Write data bits 31..0 |
| req_hi | input | 32 | Write data bits 63..32 |
| real_mode | input | 1 | Core is in real mode |
| cpl | input | 2 | Current privilege level |
| paging_en | input | 1 | Paging is enabled |
| rsp_done | output | 1 | Response valid |
| rsp_fault | output | 1 | General-protection fault |
| rsp_lo | output | 32 | Read data bits 31..0 |
| rsp_hi | output | 32 | Read data bits 63..32 |
| apic_upd | output | 1 | Interrupt-controller base changed |
| apic_base | output | 32 | Current interrupt-controller base value |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing,
- that privilege violations fault and leave the interrupt-controller base untouched,
- that capability writes and unknown indices fault,
- that an update strobe only follows a base value whose enable bit was set.

The bench scenarios cover what depends on stored values and data patterns:
- a rejected memory-type byte leaves the old contents readable,
- the long-mode-active bit survives a write,
- a cleared enable bit locks the base register.

They also cover the canonical boundary at bit 47 and the reset values after a reset in mid-run.

// File: rtl/msr_pkg.sv
package msr_pkg;

  localparam int unsigned SLOT_W = 5;

  localparam logic [31:0] IX_CAP   = 32'h0000_00FE;
  localparam logic [31:0] IX_APIC  = 32'h0000_001B;
  localparam logic [31:0] IX_VAR0  = 32'h0000_0200;
  localparam logic [31:0] IX_F64   = 32'h0000_0250;
  localparam logic [31:0] IX_F16A  = 32'h0000_0258;
  localparam logic [31:0] IX_F16B  = 32'h0000_0259;
  localparam logic [31:0] IX_F4K0  = 32'h0000_0268;
  localparam logic [31:0] IX_PAT   = 32'h0000_0277;
  localparam logic [31:0] IX_DEF   = 32'h0000_02FF;
  localparam logic [31:0] IX_FEAT  = 32'hC000_0080;
  localparam logic [31:0] IX_SEL   = 32'hC000_0081;
  localparam logic [31:0] IX_TGT64 = 32'hC000_0082;
  localparam logic [31:0] IX_TGTCM = 32'hC000_0083;
  localparam logic [31:0] IX_FMASK = 32'hC000_0084;
  localparam logic [31:0] IX_SEGF  = 32'hC000_0100;
  localparam logic [31:0] IX_SEGG  = 32'hC000_0101;
  localparam logic [31:0] IX_SWAPG = 32'hC000_0102;

  localparam int unsigned NUM_F4K  = 8;
  localparam int unsigned NUM_FIX  = 3 + NUM_F4K;
  localparam int unsigned NUM_CAN  = 5;
  localparam int unsigned LME_BIT  = 8;
  localparam int unsigned LMA_BIT  = 10;
  localparam int unsigned APIC_EN_BIT = 11;
  localparam logic [31:0] CAP_VALUE = 32'h0000_0508;

  typedef enum logic [3:0] {
    K_NONE, K_CAP, K_VBASE, K_VMASK, K_FIX, K_PAT, K_DEF,
    K_APIC, K_FEAT, K_SEL, K_CANON, K_FMASK
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [SLOT_W-1:0] slot;
  } sel_t;

  function automatic logic mt_ok(input logic [7:0] code);
    return (code == 8'h00) || (code == 8'h01) || (code == 8'h04) ||
           (code == 8'h05) || (code == 8'h06);
  endfunction

  function automatic logic pat_ok(input logic [7:0] code);
    return (code == 8'h07) || mt_ok(code);
  endfunction

  function automatic logic is_canon(input logic [63:0] v, input int unsigned va_w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if ((i >= int'(va_w) - 1) && (v[i] != v[63])) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/msr_decode.sv
module msr_decode
  import msr_pkg::*;
#(
  parameter int unsigned NUM_VAR = 8
) (
  input  logic [31:0] idx_i,
  output sel_t        sel_o
);

  localparam logic [31:0] VAR_END = IX_VAR0 + 32'(2 * NUM_VAR);
  localparam logic [31:0] F4K_END = IX_F4K0 + 32'(NUM_F4K);

  logic [SLOT_W-1:0] var_off;
  logic [SLOT_W-1:0] f4k_off;

  always_comb begin
    var_off = SLOT_W'(idx_i - IX_VAR0);
    f4k_off = SLOT_W'(idx_i - IX_F4K0);
    sel_o.kind = K_NONE;
    sel_o.slot = '0;
    if ((idx_i >= IX_VAR0) && (idx_i < VAR_END)) begin
      sel_o.kind = var_off[0] ? K_VMASK : K_VBASE;
      sel_o.slot = var_off;
    end else if ((idx_i >= IX_F4K0) && (idx_i < F4K_END)) begin
      sel_o.kind = K_FIX;
      sel_o.slot = f4k_off + SLOT_W'(3);
    end else begin
      case (idx_i)
        IX_CAP:   sel_o.kind = K_CAP;
        IX_APIC:  sel_o.kind = K_APIC;
        IX_F64:   begin sel_o.kind = K_FIX; sel_o.slot = SLOT_W'(0); end
        IX_F16A:  begin sel_o.kind = K_FIX; sel_o.slot = SLOT_W'(1); end
        IX_F16B:  begin sel_o.kind = K_FIX; sel_o.slot = SLOT_W'(2); end
        IX_PAT:   sel_o.kind = K_PAT;
        IX_DEF:   sel_o.kind = K_DEF;
        IX_FEAT:  sel_o.kind = K_FEAT;
        IX_SEL:   sel_o.kind = K_SEL;
        IX_FMASK: sel_o.kind = K_FMASK;
        IX_TGT64: begin sel_o.kind = K_CANON; sel_o.slot = SLOT_W'(0); end
        IX_TGTCM: begin sel_o.kind = K_CANON; sel_o.slot = SLOT_W'(1); end
        IX_SEGF:  begin sel_o.kind = K_CANON; sel_o.slot = SLOT_W'(2); end
        IX_SEGG:  begin sel_o.kind = K_CANON; sel_o.slot = SLOT_W'(3); end
        IX_SWAPG: begin sel_o.kind = K_CANON; sel_o.slot = SLOT_W'(4); end
        default:  sel_o.kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/msr_check.sv
module msr_check
  import msr_pkg::*;
#(
  parameter int unsigned VA_W       = 48,
  parameter logic [31:0] FEAT_SUP   = 32'h0000_0D01,
  parameter bit          IGNORE_UNK = 1'b0
) (
  input  kind_e       kind_i,
  input  logic        wr_i,
  input  logic [63:0] wdata_i,
  input  logic        real_mode_i,
  input  logic [1:0]  cpl_i,
  input  logic        paging_i,
  input  logic [31:0] feat_cur_i,
  output logic        fault_o
);

  logic priv_bad;
  logic rule_bad;
  logic pat_bad;

  always_comb begin
    priv_bad = !real_mode_i && (cpl_i != 2'd0);
    pat_bad  = 1'b0;
    for (int b = 0; b < 8; b++) begin
      if (!pat_ok(wdata_i[8*b +: 8])) pat_bad = 1'b1;
    end
    rule_bad = 1'b0;
    case (kind_i)
      K_NONE:               rule_bad = !IGNORE_UNK;
      K_CAP:                rule_bad = wr_i;
      K_VBASE, K_FIX, K_DEF: rule_bad = wr_i && !mt_ok(wdata_i[7:0]);
      K_PAT:                rule_bad = wr_i && pat_bad;
      K_FEAT:               rule_bad = wr_i &&
                              (((wdata_i & ~{32'h0, FEAT_SUP}) != 64'h0) ||
                               (paging_i && (wdata_i[LME_BIT] != feat_cur_i[LME_BIT])));
      K_CANON:              rule_bad = wr_i && !is_canon(wdata_i, VA_W);
      default:              rule_bad = 1'b0;
    endcase
    fault_o = priv_bad || rule_bad;
  end

endmodule

// File: rtl/msr_store.sv
module msr_store
  import msr_pkg::*;
#(
  parameter int unsigned NUM_VAR  = 8,
  parameter logic [31:0] APIC_RST = 32'hFEE0_0000,
  parameter logic [63:0] PAT_RST  = 64'h0007_0406_0007_0406,
  parameter logic [31:0] FEAT_SUP = 32'h0000_0D01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  sel_t        sel_i,
  input  logic [63:0] wdata_i,
  output logic [63:0] rdata_o,
  output logic [31:0] feat_o,
  output logic [31:0] apic_o,
  output logic        apic_upd_o
);

  localparam int unsigned VAR_N = 2 * NUM_VAR;
  localparam logic [31:0] LMA_M = 32'h1 << LMA_BIT;

  logic [63:0] var_q [VAR_N];
  logic [63:0] fix_q [NUM_FIX];
  logic [63:0] can_q [NUM_CAN];
  logic [63:0] pat_q, sel_q;
  logic [31:0] def_q, apic_q, feat_q, fmask_q;

  logic [VAR_N-1:0]   var_en;
  logic [NUM_FIX-1:0] fix_en;
  logic [NUM_CAN-1:0] can_en;
  logic pat_en, sel_en, def_en, apic_en, feat_en, fmask_en;
  logic [31:0] feat_d;

  for (genvar g = 0; g < VAR_N; g++) begin : g_var_en
    assign var_en[g] = we_i && ((sel_i.kind == K_VBASE) || (sel_i.kind == K_VMASK)) &&
                       (sel_i.slot == SLOT_W'(g));
  end
  for (genvar g = 0; g < NUM_FIX; g++) begin : g_fix_en
    assign fix_en[g] = we_i && (sel_i.kind == K_FIX) && (sel_i.slot == SLOT_W'(g));
  end
  for (genvar g = 0; g < NUM_CAN; g++) begin : g_can_en
    assign can_en[g] = we_i && (sel_i.kind == K_CANON) && (sel_i.slot == SLOT_W'(g));
  end

  always_comb begin
    pat_en   = we_i && (sel_i.kind == K_PAT);
    sel_en   = we_i && (sel_i.kind == K_SEL);
    def_en   = we_i && (sel_i.kind == K_DEF);
    feat_en  = we_i && (sel_i.kind == K_FEAT);
    fmask_en = we_i && (sel_i.kind == K_FMASK);
    apic_en  = we_i && (sel_i.kind == K_APIC) && apic_q[APIC_EN_BIT];
    feat_d   = (wdata_i[31:0] & FEAT_SUP & ~LMA_M) | (feat_q & LMA_M);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < VAR_N; i++) var_q[i] <= '0;
    end else begin
      for (int i = 0; i < VAR_N; i++) if (var_en[i]) var_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_FIX; i++) fix_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_FIX; i++) if (fix_en[i]) fix_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CAN; i++) can_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CAN; i++) if (can_en[i]) can_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q   <= PAT_RST;
      sel_q   <= '0;
      def_q   <= '0;
      feat_q  <= '0;
      fmask_q <= '0;
      apic_q  <= APIC_RST | (32'h1 << APIC_EN_BIT);
    end else begin
      if (pat_en)   pat_q   <= wdata_i;
      if (sel_en)   sel_q   <= wdata_i;
      if (def_en)   def_q   <= wdata_i[31:0];
      if (feat_en)  feat_q  <= feat_d;
      if (fmask_en) fmask_q <= wdata_i[31:0];
      if (apic_en)  apic_q  <= wdata_i[31:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i.kind)
      K_CAP:   rdata_o = {32'h0, CAP_VALUE};
      K_VBASE, K_VMASK:
        for (int i = 0; i < VAR_N; i++) if (sel_i.slot == SLOT_W'(i)) rdata_o = var_q[i];
      K_FIX:
        for (int i = 0; i < NUM_FIX; i++) if (sel_i.slot == SLOT_W'(i)) rdata_o = fix_q[i];
      K_CANON:
        for (int i = 0; i < NUM_CAN; i++) if (sel_i.slot == SLOT_W'(i)) rdata_o = can_q[i];
      K_PAT:   rdata_o = pat_q;
      K_SEL:   rdata_o = sel_q;
      K_DEF:   rdata_o = {32'h0, def_q};
      K_FEAT:  rdata_o = {32'h0, feat_q};
      K_FMASK: rdata_o = {32'h0, fmask_q};
      K_APIC:  rdata_o = {32'h0, apic_q};
      default: rdata_o = '0;
    endcase
  end

  assign feat_o     = feat_q;
  assign apic_o     = apic_q;
  assign apic_upd_o = apic_en;

  // R7: the long-mode-active bit is never changed by a committed write
  assert_lma_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    feat_en |=> (feat_q[LMA_BIT] == $past(feat_q[LMA_BIT])));

endmodule

// File: rtl/msr_unit.sv
module msr_unit
  import msr_pkg::*;
#(
  parameter int unsigned NUM_VAR    = 8,
  parameter int unsigned VA_W       = 48,
  parameter logic [31:0] FEAT_SUP   = 32'h0000_0D01,
  parameter logic [31:0] APIC_RST   = 32'hFEE0_0000,
  parameter logic [63:0] PAT_RST    = 64'h0007_0406_0007_0406,
  parameter bit          IGNORE_UNK = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_index,
  input  logic [31:0] req_lo,
  input  logic [31:0] req_hi,
  input  logic        real_mode,
  input  logic [1:0]  cpl,
  input  logic        paging_en,
  output logic        rsp_done,
  output logic        rsp_fault,
  output logic [31:0] rsp_lo,
  output logic [31:0] rsp_hi,
  output logic        apic_upd,
  output logic [31:0] apic_base
);

  logic [1:0]  rst_sync_q;
  logic        rst_ni;
  sel_t        sel;
  logic        fault;
  logic        commit;
  logic [63:0] wdata, rdata;
  logic [31:0] feat_cur;
  logic        upd_now;

  logic        done_d, fault_d, upd_d;
  logic [31:0] lo_d, hi_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign wdata = {req_hi, req_lo};

  msr_decode #(.NUM_VAR(NUM_VAR)) u_dec (
    .idx_i (req_index),
    .sel_o (sel)
  );

  msr_check #(.VA_W(VA_W), .FEAT_SUP(FEAT_SUP), .IGNORE_UNK(IGNORE_UNK)) u_chk (
    .kind_i      (sel.kind),
    .wr_i        (req_write),
    .wdata_i     (wdata),
    .real_mode_i (real_mode),
    .cpl_i       (cpl),
    .paging_i    (paging_en),
    .feat_cur_i  (feat_cur),
    .fault_o     (fault)
  );

  assign commit = req_valid && req_write && !fault;

  msr_store #(.NUM_VAR(NUM_VAR), .APIC_RST(APIC_RST), .PAT_RST(PAT_RST),
              .FEAT_SUP(FEAT_SUP)) u_st (
    .clk        (clk),
    .rst_n      (rst_ni),
    .we_i       (commit),
    .sel_i      (sel),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .feat_o     (feat_cur),
    .apic_o     (apic_base),
    .apic_upd_o (upd_now)
  );

  always_comb begin
    done_d  = req_valid;
    fault_d = req_valid && fault;
    upd_d   = upd_now;
    if (req_valid && !req_write && !fault) begin
      lo_d = rdata[31:0];
      hi_d = rdata[63:32];
    end else begin
      lo_d = '0;
      hi_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_done  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_lo    <= '0;
      rsp_hi    <= '0;
      apic_upd  <= 1'b0;
    end else begin
      rsp_done  <= done_d;
      rsp_fault <= fault_d;
      rsp_lo    <= lo_d;
      rsp_hi    <= hi_d;
      apic_upd  <= upd_d;
    end
  end

  // R2: a response follows every request, and only a request
  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid |=> rsp_done);
  assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_valid |=> !rsp_done);
  // R1: a privilege violation faults and leaves the base register unchanged
  assert_priv_fault_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && !real_mode && (cpl != 2'd0)) |=> (rsp_fault && $stable(apic_base)));
  // R5: the capability register cannot be written
  assert_cap_ro_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_write && (req_index == IX_CAP)) |=> rsp_fault);
  // R10: unknown indices fault unless the ignore option is set
  assert_unknown_fault_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && (sel.kind == K_NONE) && !IGNORE_UNK) |=> rsp_fault);
  // R9: an update strobe only follows a base value that had its enable bit set
  assert_upd_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    apic_upd |-> $past(apic_base[APIC_EN_BIT]));

endmodule

// File: tb/sim_msr_unit.sv
module sim_msr_unit;

  localparam logic [31:0] CAP = 32'h0000_00FE, APIC = 32'h0000_001B;
  localparam logic [31:0] VB0 = 32'h0000_0200, VM0 = 32'h0000_0201;
  localparam logic [31:0] F64 = 32'h0000_0250, F4K = 32'h0000_0268;
  localparam logic [31:0] PAT = 32'h0000_0277, DEF = 32'h0000_02FF;
  localparam logic [31:0] FEAT = 32'hC000_0080, SELR = 32'hC000_0081;
  localparam logic [31:0] TGT = 32'hC000_0082, FMSK = 32'hC000_0084;
  localparam logic [31:0] SEGF = 32'hC000_0100, SWPG = 32'hC000_0102;
  localparam logic [31:0] UNK = 32'h0000_0123;

  typedef struct packed {
    logic        wr;
    logic [31:0] idx;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        rm;
    logic [1:0]  pl;
    logic        pg;
    logic        flt;
    logic [31:0] elo;
    logic [31:0] ehi;
    logic        upd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 51;
  localparam vec_t VEC [NV] = '{
    '{1'b0, CAP,  32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h508, 32'h0, 1'b0, 4'd5},   // R5
    '{1'b1, CAP,  32'h1, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 4'd5},     // R5
    '{1'b0, APIC, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'hFEE00800, 32'h0, 1'b0, 4'd11}, // R11
    '{1'b0, PAT,  32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h00070406, 32'h00070406, 1'b0, 4'd11},
    '{1'b0, VB0,  32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd11},
    '{1'b1, VB0,  32'h12345006, 32'hF, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd3}, // R3
    '{1'b0, VB0,  32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h12345006, 32'hF, 1'b0, 4'd3},
    '{1'b1, VB0,  32'h02, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 4'd3},
    '{1'b0, VB0,  32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h12345006, 32'hF, 1'b0, 4'd3},
    '{1'b1, VM0,  32'hFFF00002, 32'h3, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd3},
    '{1'b0, VM0,  32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'hFFF00002, 32'h3, 1'b0, 4'd3},
    '{1'b1, F64,  32'h06060603, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 4'd3},
    '{1'b1, F4K,  32'h05, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd3},
    '{1'b0, F4K,  32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h05, 32'h0, 1'b0, 4'd3},
    '{1'b1, DEF,  32'hC06, 32'hAB, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd12},  // R12
    '{1'b0, DEF,  32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'hC06, 32'h0, 1'b0, 4'd12},
    '{1'b1, DEF,  32'h07, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 4'd3},
    '{1'b1, PAT,  32'h07060504, 32'h01000706, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd4}, // R4
    '{1'b0, PAT,  32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h07060504, 32'h01000706, 1'b0, 4'd4},
    '{1'b1, PAT,  32'h07060504, 32'h01020706, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 4'd4},
    '{1'b0, PAT,  32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h07060504, 32'h01000706, 1'b0, 4'd4},
    '{1'b1, FEAT, 32'h001, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd6},   // R6
    '{1'b0, FEAT, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h001, 32'h0, 1'b0, 4'd6},
    '{1'b1, FEAT, 32'h002, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 4'd6},
    '{1'b1, FEAT, 32'h501, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd7},   // R7
    '{1'b0, FEAT, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h101, 32'h0, 1'b0, 4'd7},
    '{1'b1, FEAT, 32'h001, 32'h0, 1'b0, 2'd0, 1'b1, 1'b1, 32'h0, 32'h0, 1'b0, 4'd7},
    '{1'b1, FEAT, 32'h901, 32'h0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, 4'd7},
    '{1'b0, FEAT, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h901, 32'h0, 1'b0, 4'd7},
    '{1'b1, TGT,  32'h0, 32'hFFFF8000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd8}, // R8
    '{1'b0, TGT,  32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'hFFFF8000, 1'b0, 4'd8},
    '{1'b1, TGT,  32'h0, 32'h00008000, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 4'd8},
    '{1'b1, SEGF, 32'hFFFFFFFF, 32'h00007FFF, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd8},
    '{1'b0, SEGF, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00007FFF, 1'b0, 4'd8},
    '{1'b1, SWPG, 32'h0, 32'hFFFF0000, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 4'd8},
    '{1'b1, SELR, 32'h0, 32'h12345678, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd8},
    '{1'b0, SELR, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h12345678, 1'b0, 4'd8},
    '{1'b1, FMSK, 32'h47700, 32'hFF, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd12},
    '{1'b0, FMSK, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h47700, 32'h0, 1'b0, 4'd12},
    '{1'b0, UNK,  32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 4'd10},    // R10
    '{1'b1, UNK,  32'h5, 32'h5, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 4'd10},
    '{1'b0, CAP,  32'h0, 32'h0, 1'b0, 2'd3, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 4'd1},     // R1
    '{1'b1, VB0,  32'h06, 32'h0, 1'b0, 2'd3, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 4'd1},
    '{1'b0, VB0,  32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h12345006, 32'hF, 1'b0, 4'd1},
    '{1'b0, CAP,  32'h0, 32'h0, 1'b1, 2'd3, 1'b0, 1'b0, 32'h508, 32'h0, 1'b0, 4'd1},
    '{1'b1, APIC, 32'hFEC00800, 32'h5, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 4'd9}, // R9
    '{1'b0, APIC, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'hFEC00800, 32'h0, 1'b0, 4'd9},
    '{1'b1, APIC, 32'hFEB00000, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 4'd9},
    '{1'b0, APIC, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'hFEB00000, 32'h0, 1'b0, 4'd9},
    '{1'b1, APIC, 32'hFE000800, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd9},
    '{1'b0, APIC, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'hFEB00000, 32'h0, 1'b0, 4'd9}
  };

  logic        clk, rst_n;
  logic        req_valid, req_write, real_mode, paging_en;
  logic [31:0] req_index, req_lo, req_hi;
  logic [1:0]  cpl;
  logic        rsp_done, rsp_fault, apic_upd;
  logic [31:0] rsp_lo, rsp_hi, apic_base;

  int n_run, n_fail;

  msr_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_lo(req_lo), .req_hi(req_hi),
    .real_mode(real_mode), .cpl(cpl), .paging_en(paging_en),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_lo(rsp_lo), .rsp_hi(rsp_hi),
    .apic_upd(apic_upd), .apic_base(apic_base)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.rq);
    req_valid = 1'b1; req_write = v.wr; req_index = v.idx;
    req_lo = v.lo; req_hi = v.hi; real_mode = v.rm; cpl = v.pl; paging_en = v.pg;
    @(negedge clk);
    req_valid = 1'b0; real_mode = 1'b0; cpl = 2'd0; paging_en = 1'b0;
    check({tag, " done"},  {63'h0, rsp_done}, 64'h1);
    check({tag, " fault"}, {63'h0, rsp_fault}, {63'h0, v.flt});
    check({tag, " data"},  {rsp_hi, rsp_lo}, {v.ehi, v.elo});
    check({tag, " upd"},   {63'h0, apic_upd}, {63'h0, v.upd});
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    req_valid = 1'b0; req_write = 1'b0; req_index = '0; req_lo = '0; req_hi = '0;
    real_mode = 1'b0; cpl = 2'd0; paging_en = 1'b0;
    do_reset();
    // R11 / R2: reset state
    check("R2 idle done", {63'h0, rsp_done}, 64'h0);
    check("R11 apic reset", {32'h0, apic_base}, 64'hFEE00800);
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // R2: a cycle without a request gives no response
    @(negedge clk);
    check("R2 no done when idle", {63'h0, rsp_done}, 64'h0);
    // R11: a mid-run reset restores the reset values
    do_reset();
    run_vec('{1'b0, VB0, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd11});
    run_vec('{1'b0, APIC, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'hFEE00800, 32'h0, 1'b0, 4'd11});
    run_vec('{1'b0, PAT, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h00070406, 32'h00070406, 1'b0, 4'd11});
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule